// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V instruction into the 32-bit base-ISA word that does the same thing. It covers the RV32 integer compressed subset:
- word loads and stores, both relative to the stack pointer and relative to a compressed base register;
- the unconditional jumps, with and without a link;
- the compare-with-zero branches;
- the constant loads (small immediate and upper immediate);
- the immediate adds, including the stack-pointer adjust and the stack-pointer-relative pointer generation;
- the immediate shifts and the immediate AND.

For each of these it gathers the scattered immediate bits, scales them, and sign- or zero-extends them as the format needs. It then emits the I, S, B, J or U form with the right opcode. It also flags code points that are reserved or outside the supported subset, and it marks HINT code points separately. A HINT still gets a well-formed expansion that has no architectural effect.

The unit is purely combinational and sits between instruction alignment and decode. A word arrives with a valid strobe, and the result appears in the same cycle with `out_valid` equal to `in_valid`. There is no ready signal and no back-pressure, because the block holds no state: the consumer must take or discard the result in the cycle it is presented. Holding the input steady holds the output steady.

A word whose two low bits are `11` is already a full-length instruction. With the default `PASS_32 = 1` it passes through unchanged. With `PASS_32 = 0` it is flagged illegal.

Top module: `cx_expand`

## Requirements
- R1: `out_valid` equals `in_valid` in the same cycle. While `in_valid` is low, `out_word`, `out_illegal` and `out_hint` are all zero, whatever `in_word` holds.
- R2: With `PASS_32 = 1`, a word whose bits [1:0] are `11` appears unchanged on `out_word`, with both flags low.
- R3: An illegal result drives `out_word` to zero and never raises `out_hint` at the same time. The all-zero halfword is illegal.
- R4: Quadrant 0 (bits [1:0] = `00`), bits [15:13] = `000`: pointer generation. The destination is x8+bits[4:2]. The unsigned immediate is built as imm[5:4]=b[12:11], imm[9:6]=b[10:7], imm[2]=b[6], imm[3]=b[5]. The result is `addi rd, x2, imm`, and it is illegal when imm is zero.
- R5: Quadrant 0, bits [15:13] = `010` (load) or `110` (store): word access with base x8+b[9:7]. The data register is x8+b[4:2]. The unsigned offset is built as off[5:3]=b[12:10], off[2]=b[6], off[6]=b[5]. The result is `lw` or `sw` with funct3 `010`.
- R6: Quadrant 2 (bits [1:0] = `10`), bits [15:13] = `010`: stack load `lw rd, off(x2)`, with rd=b[11:7] and off[5]=b[12], off[4:2]=b[6:4], off[7:6]=b[3:2]. It is illegal when rd is x0. With bits [15:13] = `110` it is the stack store `sw b[6:2], off(x2)`, with off[5:2]=b[12:9] and off[7:6]=b[8:7].
- R7: Quadrant 1 (bits [1:0] = `01`), bits [15:13] = `101` gives `jal x0` and `001` gives `jal x1`. The sign-extended 12-bit offset is off[11]=b12, off[4]=b11, off[9:8]=b[10:9], off[10]=b8, off[6]=b7, off[7]=b6, off[3:1]=b[5:3], off[5]=b2.
- R8: Quadrant 1, bits [15:13] = `110` gives `beq` and `111` gives `bne`, comparing x8+b[9:7] against x0. The sign-extended offset is off[8]=b12, off[4:3]=b[11:10], off[7:6]=b[6:5], off[2:1]=b[4:3], off[5]=b2.
- R9: Quadrant 1, bits [15:13] = `010`: `addi rd, x0, imm`, with rd=b[11:7] and a sign-extended 6-bit imm={b12,b[6:2]}. It is a HINT when rd is x0.
- R10: Quadrant 1, bits [15:13] = `011`:
  - When rd=b[11:7] is x2, it is the stack adjust `addi x2, x2, imm`, with imm[9]=b12, imm[4]=b6, imm[6]=b5, imm[8:7]=b[4:3], imm[5]=b2, sign-extended; it is illegal when imm is zero.
  - Otherwise it is `lui rd` with {b12,b[6:2]} sign-extended into result bits [31:12]. It is illegal when that field is zero, and a HINT when rd is x0.
- R11: Quadrant 1, bits [15:13] = `000`: `addi rd, rd, imm`, with a sign-extended imm={b12,b[6:2]}. With rd=x0 and imm=0 it is the plain no-op `0x00000013`, not flagged. Exactly one of (rd is x0) and (imm is zero) makes it a HINT.
- R12: The shifts and the immediate AND:
  - Quadrant 1, bits [15:13] = `100`: b[11:10] `00` gives a logical right shift, `01` an arithmetic right shift and `10` `andi`, all on x8+b[9:7]. `andi` uses a sign-extended imm={b12,b[6:2]}.
  - Quadrant 2, bits [15:13] = `000`: left shift on rd=b[11:7].
  - For the shifts, shamt={b12,b[6:2]}. A set b12 is illegal, and a zero shamt is a HINT. A left shift with rd=x0 is also a HINT.
- R13: Every compressed code point outside R4 to R12 is illegal: floating-point forms, quadrant 1 `100` with b[11:10]=`11`, and quadrant 2 `100`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Strobe marking `in_word` as carrying an instruction |
| in_word | input | 32 | Instruction; bits [15:0] hold a compressed one, all 32 bits are used for pass-through |
| out_valid | output | 1 | Follows `in_valid` in the same cycle |
| out_word | output | 32 | Expanded 32-bit instruction, zero when illegal or not valid |
| out_illegal | output | 1 | Reserved, non-standard or unsupported code point |
| out_hint | output | 1 | HINT code point with a harmless expansion |

## Verification
Every result is combinational and therefore due in the same cycle as its stimulus: no register lies between `in_word` and any output. Each scenario task drives `in_valid` and `in_word` just after a falling clock edge and samples all four outputs 1 ns later, well before the next rising edge. No check depends on edge ordering or latency. The expected words are rebuilt in the bench by separate encoders, one for the compressed side and one for the base side, so the operand order and immediate packing are checked at the ports.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned HALF_W = 16;

  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LUI    = 7'b0110111;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;

  typedef struct packed {
    logic [INSN_W-1:0] word;
    logic              illegal;
    logic              hint;
  } cx_res_t;

  // compressed 3-bit register field selects x8..x15
  function automatic logic [4:0] creg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [INSN_W-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                              input logic [2:0] f3, input logic [4:0] rd,
                                              input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [INSN_W-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
  endfunction

  function automatic logic [INSN_W-1:0] enc_b(input logic [12:0] imm, input logic [4:0] rs1,
                                              input logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], OP_BRANCH};
  endfunction

  function automatic logic [INSN_W-1:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OP_JAL};
  endfunction

  function automatic logic [INSN_W-1:0] enc_u(input logic [19:0] imm, input logic [4:0] rd);
    return {imm, rd, OP_LUI};
  endfunction

  function automatic cx_res_t mk(input logic [INSN_W-1:0] w, input logic h);
    cx_res_t r;
    r.word    = w;
    r.illegal = 1'b0;
    r.hint    = h;
    return r;
  endfunction

  function automatic cx_res_t bad();
    cx_res_t r;
    r.word    = '0;
    r.illegal = 1'b1;
    r.hint    = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/cx_q0.sv
// Quadrant 0: pointer generation and register-based word loads/stores.
module cx_q0
  import cx_pkg::*;
(
  input  logic [HALF_W-1:2] ci,
  output cx_res_t           res
);
  logic [2:0]  f3;
  logic [4:0]  rdp;
  logic [4:0]  rs1p;
  logic [11:0] spn_imm;
  logic [11:0] wo_imm;

  assign f3      = ci[15:13];
  assign rdp     = creg(ci[4:2]);
  assign rs1p    = creg(ci[9:7]);
  assign spn_imm = {2'b00, ci[10:7], ci[12:11], ci[5], ci[6], 2'b00};
  assign wo_imm  = {5'b00000, ci[5], ci[12:10], ci[6], 2'b00};

  always_comb begin
    res = bad();
    case (f3)
      // R4
      3'b000: if (spn_imm != '0) res = mk(enc_i(spn_imm, 5'd2, 3'b000, rdp, OP_IMM), 1'b0);
      // R5
      3'b010: res = mk(enc_i(wo_imm, rs1p, 3'b010, rdp, OP_LOAD), 1'b0);
      3'b110: res = mk(enc_s(wo_imm, rdp, rs1p, 3'b010), 1'b0);
      // R13
      default: res = bad();
    endcase
  end

  always_comb begin
    if (!res.illegal && (res.word[6:0] == OP_LOAD || res.word[6:0] == OP_STORE)) begin
      // R5
      base_creg_chk: assert (res.word[19:15] == {2'b01, ci[9:7]});
    end
    if (!res.illegal && f3 == 3'b000) begin
      // R4
      spn_nonzero_chk: assert (res.word[31:20] != 12'd0 && res.word[19:15] == 5'd2);
    end
  end
endmodule

// File: rtl/cx_q1.sv
// Quadrant 1: jumps, branches, constants, immediate arithmetic.
module cx_q1
  import cx_pkg::*;
(
  input  logic [HALF_W-1:2] ci,
  output cx_res_t           res
);
  logic [2:0]  f3;
  logic [4:0]  rd;
  logic [4:0]  rdp;
  logic [5:0]  imm6;
  logic [11:0] imm12s;
  logic [11:0] j_off;
  logic [20:0] j_imm;
  logic [8:0]  b_off;
  logic [12:0] b_imm;
  logic [9:0]  a16;
  logic [11:0] a16_imm;
  logic [19:0] lui_imm;
  logic [11:0] sh_imm;

  assign f3      = ci[15:13];
  assign rd      = ci[11:7];
  assign rdp     = creg(ci[9:7]);
  assign imm6    = {ci[12], ci[6:2]};
  assign imm12s  = {{6{ci[12]}}, imm6};
  assign j_off   = {ci[12], ci[8], ci[10:9], ci[6], ci[7], ci[2], ci[11], ci[5:3], 1'b0};
  assign j_imm   = {{9{ci[12]}}, j_off};
  assign b_off   = {ci[12], ci[6:5], ci[2], ci[11:10], ci[4:3], 1'b0};
  assign b_imm   = {{4{ci[12]}}, b_off};
  assign a16     = {ci[12], ci[4:3], ci[5], ci[2], ci[6], 4'b0000};
  assign a16_imm = {{2{ci[12]}}, a16};
  assign lui_imm = {{14{ci[12]}}, imm6};
  assign sh_imm  = {1'b0, ci[10], 4'b0000, imm6};

  always_comb begin
    res = bad();
    case (f3)
      // R11
      3'b000: res = mk(enc_i(imm12s, rd, 3'b000, rd, OP_IMM), (rd == 5'd0) != (imm6 == 6'd0));
      // R7
      3'b001: res = mk(enc_j(j_imm, 5'd1), 1'b0);
      3'b101: res = mk(enc_j(j_imm, 5'd0), 1'b0);
      // R9
      3'b010: res = mk(enc_i(imm12s, 5'd0, 3'b000, rd, OP_IMM), rd == 5'd0);
      // R10
      3'b011: begin
        if (rd == 5'd2) begin
          if (a16 != '0) res = mk(enc_i(a16_imm, 5'd2, 3'b000, 5'd2, OP_IMM), 1'b0);
        end else if (imm6 != '0) begin
          res = mk(enc_u(lui_imm, rd), rd == 5'd0);
        end
      end
      // R12
      3'b100: begin
        case (ci[11:10])
          2'b00, 2'b01: if (!ci[12]) res = mk(enc_i(sh_imm, rdp, 3'b101, rdp, OP_IMM), imm6 == 6'd0);
          2'b10:        res = mk(enc_i(imm12s, rdp, 3'b111, rdp, OP_IMM), 1'b0);
          default:      res = bad(); // R13
        endcase
      end
      // R8
      default: res = mk(enc_b(b_imm, rdp, {2'b00, ci[13]}), 1'b0);
    endcase
  end

  always_comb begin
    if (!res.illegal && res.word[6:0] == OP_JAL) begin
      // R7
      jal_link_chk: assert (res.word[11:7] == (ci[15] ? 5'd0 : 5'd1));
    end
    if (!res.illegal && res.word[6:0] == OP_BRANCH) begin
      // R8
      br_zero_rs2_chk: assert (res.word[24:20] == 5'd0 && res.word[19:18] == 2'b01 && res.word[8] == ci[3]);
    end
    if (f3 == 3'b100 && ci[11:10] != 2'b10 && ci[12]) begin
      // R12
      shamt5_trap_chk: assert (res.illegal);
    end
  end
endmodule

// File: rtl/cx_q2.sv
// Quadrant 2: left shift and stack-pointer word loads/stores.
module cx_q2
  import cx_pkg::*;
(
  input  logic [HALF_W-1:2] ci,
  output cx_res_t           res
);
  logic [2:0]  f3;
  logic [4:0]  rd;
  logic [5:0]  shamt;
  logic [11:0] lwsp_imm;
  logic [11:0] swsp_imm;

  assign f3       = ci[15:13];
  assign rd       = ci[11:7];
  assign shamt    = {ci[12], ci[6:2]};
  assign lwsp_imm = {4'b0000, ci[3:2], ci[12], ci[6:4], 2'b00};
  assign swsp_imm = {4'b0000, ci[8:7], ci[12:9], 2'b00};

  always_comb begin
    res = bad();
    case (f3)
      // R12
      3'b000: if (!ci[12]) res = mk(enc_i({6'b000000, shamt}, rd, 3'b001, rd, OP_IMM),
                                    rd == 5'd0 || shamt == 6'd0);
      // R6
      3'b010: if (rd != 5'd0) res = mk(enc_i(lwsp_imm, 5'd2, 3'b010, rd, OP_LOAD), 1'b0);
      3'b110: res = mk(enc_s(swsp_imm, ci[6:2], 5'd2, 3'b010), 1'b0);
      // R13
      default: res = bad();
    endcase
  end

  always_comb begin
    if (!res.illegal && (res.word[6:0] == OP_LOAD || res.word[6:0] == OP_STORE)) begin
      // R6
      sp_base_chk: assert (res.word[19:15] == 5'd2 && res.word[14:12] == 3'b010);
    end
    if (f3 == 3'b010 && rd == 5'd0) begin
      // R6
      lwsp_x0_trap_chk: assert (res.illegal);
    end
  end
endmodule

// File: rtl/cx_expand.sv
// Compressed instruction expander: selects the quadrant decoder by bits [1:0].
module cx_expand
  import cx_pkg::*;
#(
  parameter bit PASS_32 = 1'b1
) (
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_word,
  output logic              out_valid,
  output logic [INSN_W-1:0] out_word,
  output logic              out_illegal,
  output logic              out_hint
);
  cx_res_t r_q0;
  cx_res_t r_q1;
  cx_res_t r_q2;
  cx_res_t r_full;
  cx_res_t sel;

  cx_q0 u_q0 (.ci(in_word[HALF_W-1:2]), .res(r_q0));
  cx_q1 u_q1 (.ci(in_word[HALF_W-1:2]), .res(r_q1));
  cx_q2 u_q2 (.ci(in_word[HALF_W-1:2]), .res(r_q2));

  generate
    if (PASS_32) begin : g_pass
      assign r_full = mk(in_word, 1'b0);
    end else begin : g_trap
      assign r_full = bad();
    end
  endgenerate

  always_comb begin
    case (in_word[1:0])
      2'b00:   sel = r_q0;
      2'b01:   sel = r_q1;
      2'b10:   sel = r_q2;
      default: sel = r_full;
    endcase
  end

  assign out_valid   = in_valid;
  assign out_word    = (in_valid && !sel.illegal) ? sel.word : '0;
  assign out_illegal = in_valid & sel.illegal;
  assign out_hint    = in_valid & ~sel.illegal & sel.hint;

  always_comb begin
    // R3
    flag_excl_chk: assert (!(out_illegal && out_hint));
    if (in_valid && in_word[HALF_W-1:0] == '0) begin
      // R3
      zero_half_chk: assert (out_illegal && out_word == '0);
    end
    if (!in_valid) begin
      // R1
      idle_quiet_chk: assert (!out_illegal && !out_hint && out_word == '0);
    end
    if (PASS_32 && in_valid && in_word[1:0] == 2'b11) begin
      // R2
      pass_thru_chk: assert (out_word == in_word && !out_illegal);
    end
  end
endmodule

// File: tb/sim_cx_expand.sv
`timescale 1ns/1ps
module sim_cx_expand;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_illegal;
  logic        out_hint;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cx_expand u0 (
    .in_valid(in_valid), .in_word(in_word), .out_valid(out_valid),
    .out_word(out_word), .out_illegal(out_illegal), .out_hint(out_hint)
  );

  // ---- base-format encoders (expected side) ----
  function automatic logic [31:0] e_i(input int imm, input int rs1, input int f3, input int rd, input logic [6:0] op);
    logic [11:0] i = imm[11:0];
    return {i, rs1[4:0], f3[2:0], rd[4:0], op};
  endfunction
  function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
    logic [11:0] i = imm[11:0];
    return {i[11:5], rs2[4:0], rs1[4:0], 3'b010, i[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input int imm, input int rs1, input int f3);
    logic [12:0] i = imm[12:0];
    return {i[12], i[10:5], 5'd0, rs1[4:0], f3[2:0], i[4:1], i[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(input int imm, input int rd);
    logic [20:0] i = imm[20:0];
    return {i[20], i[10:1], i[11], i[19:12], rd[4:0], 7'b1101111};
  endfunction
  function automatic logic [31:0] e_u(input int imm20, input int rd);
    logic [19:0] i = imm20[19:0];
    return {i, rd[4:0], 7'b0110111};
  endfunction

  // ---- compressed encoders (stimulus side) ----
  function automatic logic [15:0] c_spn(input int rdp, input int u);
    logic [9:0] o = u[9:0];
    return {3'b000, o[5:4], o[9:6], o[2], o[3], rdp[2:0], 2'b00};
  endfunction
  function automatic logic [15:0] c_wm(input int f3, input int rs1p, input int rp, input int off);
    logic [6:0] o = off[6:0];
    return {f3[2:0], o[5:3], rs1p[2:0], o[2], o[6], rp[2:0], 2'b00};
  endfunction
  function automatic logic [15:0] c_lwsp(input int rd, input int off);
    logic [7:0] o = off[7:0];
    return {3'b010, o[5], rd[4:0], o[4:2], o[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] c_swsp(input int rs2, input int off);
    logic [7:0] o = off[7:0];
    return {3'b110, o[5:2], o[7:6], rs2[4:0], 2'b10};
  endfunction
  function automatic logic [15:0] c_j(input int f3, input int off);
    logic [11:0] o = off[11:0];
    return {f3[2:0], o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_b(input int f3, input int rs1p, input int off);
    logic [8:0] o = off[8:0];
    return {f3[2:0], o[8], o[4:3], rs1p[2:0], o[7:6], o[2:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_ci(input int f3, input int rd, input int imm, input logic [1:0] q);
    logic [5:0] i = imm[5:0];
    return {f3[2:0], i[5], rd[4:0], i[4:0], q};
  endfunction
  function automatic logic [15:0] c_a16(input int imm);
    logic [9:0] i = imm[9:0];
    return {3'b011, i[9], 5'd2, i[4], i[6], i[8:7], i[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_sh(input int f2, input int rdp, input int imm);
    logic [5:0] i = imm[5:0];
    return {3'b100, i[5], f2[1:0], rdp[2:0], i[4:0], 2'b01};
  endfunction

  task automatic drive(input logic v, input logic [31:0] w);
    @(negedge clk);
    in_valid = v;
    in_word  = w;
    #1;
  endtask

  task automatic expect_out(input string tag, input logic v, input logic [31:0] w,
                            input logic ill, input logic h);
    logic [34:0] got;
    logic [34:0] exp;
    got = {out_valid, out_illegal, out_hint, out_word};
    exp = {v, ill, h, w};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got v=%b ill=%b hint=%b word=%h, expected v=%b ill=%b hint=%b word=%h",
               tag, got[34], got[33], got[32], got[31:0], v, ill, h, w);
    end
  endtask

  task automatic run_c(input string tag, input logic [15:0] c, input logic [31:0] w,
                       input logic ill, input logic h);
    drive(1'b1, {16'h0000, c});
    expect_out(tag, 1'b1, w, ill, h);
  endtask

  task automatic t_reset_idle();
    drive(1'b0, 32'h0000_0000);
    expect_out("R1 idle after reset", 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b0, {16'h0, c_lwsp(5, 8)});
    expect_out("R1 legal word ignored while not valid", 1'b0, 32'h0, 1'b0, 1'b0);
    drive(1'b0, 32'h0000_8082);
    expect_out("R1 illegal word ignored while not valid", 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_passthru();
    drive(1'b1, 32'h00A0_0093);
    expect_out("R2 full-length addi passes through", 1'b1, 32'h00A0_0093, 1'b0, 1'b0);
    drive(1'b1, 32'hFFFF_FFFF);
    expect_out("R2 all-ones passes through", 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_spn();
    run_c("R3 all-zero halfword illegal", 16'h0000, 32'h0, 1'b1, 1'b0);
    run_c("R4 pointer gen max imm", c_spn(3, 1020), e_i(1020, 2, 0, 11, 7'b0010011), 1'b0, 1'b0);
    run_c("R4 pointer gen imm 4", c_spn(0, 4), e_i(4, 2, 0, 8, 7'b0010011), 1'b0, 1'b0);
    run_c("R4 pointer gen zero imm reserved", c_spn(5, 0), 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_reg_mem();
    run_c("R5 lw x15,124(x9)", c_wm(2, 1, 7, 124), e_i(124, 9, 2, 15, 7'b0000011), 1'b0, 1'b0);
    run_c("R5 sw x8,4(x14)", c_wm(6, 6, 0, 4), e_s(4, 8, 14), 1'b0, 1'b0);
    run_c("R5 sw x13,64(x8)", c_wm(6, 0, 5, 64), e_s(64, 13, 8), 1'b0, 1'b0);
  endtask

  task automatic t_sp_mem();
    run_c("R6 lwsp x5,252", c_lwsp(5, 252), e_i(252, 2, 2, 5, 7'b0000011), 1'b0, 1'b0);
    run_c("R6 lwsp rd x0 reserved", c_lwsp(0, 16), 32'h0, 1'b1, 1'b0);
    run_c("R6 swsp x31,128", c_swsp(31, 128), e_s(128, 31, 2), 1'b0, 1'b0);
    run_c("R6 swsp x1,60", c_swsp(1, 60), e_s(60, 1, 2), 1'b0, 1'b0);
  endtask

  task automatic t_jumps();
    run_c("R7 j -2048", c_j(5, -2048), e_j(-2048, 0), 1'b0, 1'b0);
    run_c("R7 jal +2046 links x1", c_j(1, 2046), e_j(2046, 1), 1'b0, 1'b0);
    run_c("R7 j +0x2a4", c_j(5, 676), e_j(676, 0), 1'b0, 1'b0);
  endtask

  task automatic t_branches();
    run_c("R8 beqz x10,-256", c_b(6, 2, -256), e_b(-256, 10, 0), 1'b0, 1'b0);
    run_c("R8 bnez x15,+254", c_b(7, 7, 254), e_b(254, 15, 1), 1'b0, 1'b0);
    run_c("R8 beqz x8,+0x56", c_b(6, 0, 86), e_b(86, 8, 0), 1'b0, 1'b0);
  endtask

  task automatic t_li();
    run_c("R9 li x10,-32", c_ci(2, 10, -32, 2'b01), e_i(-32, 0, 0, 10, 7'b0010011), 1'b0, 1'b0);
    run_c("R9 li x0 is hint", c_ci(2, 0, 5, 2'b01), e_i(5, 0, 0, 0, 7'b0010011), 1'b0, 1'b1);
  endtask

  task automatic t_lui_a16();
    run_c("R10 lui x7 negative", c_ci(3, 7, -32, 2'b01), e_u(-32, 7), 1'b0, 1'b0);
    run_c("R10 lui x9 +31", c_ci(3, 9, 31, 2'b01), e_u(31, 9), 1'b0, 1'b0);
    run_c("R10 lui zero imm reserved", c_ci(3, 7, 0, 2'b01), 32'h0, 1'b1, 1'b0);
    run_c("R10 lui rd x0 hint", c_ci(3, 0, 1, 2'b01), e_u(1, 0), 1'b0, 1'b1);
    run_c("R10 sp adjust -512", c_a16(-512), e_i(-512, 2, 0, 2, 7'b0010011), 1'b0, 1'b0);
    run_c("R10 sp adjust +496", c_a16(496), e_i(496, 2, 0, 2, 7'b0010011), 1'b0, 1'b0);
    run_c("R10 sp adjust zero reserved", c_a16(0), 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_addi();
    run_c("R11 addi x3,31", c_ci(0, 3, 31, 2'b01), e_i(31, 3, 0, 3, 7'b0010011), 1'b0, 1'b0);
    run_c("R11 addi x20,-1", c_ci(0, 20, -1, 2'b01), e_i(-1, 20, 0, 20, 7'b0010011), 1'b0, 1'b0);
    run_c("R11 nop", c_ci(0, 0, 0, 2'b01), 32'h0000_0013, 1'b0, 1'b0);
    run_c("R11 zero imm hint", c_ci(0, 4, 0, 2'b01), e_i(0, 4, 0, 4, 7'b0010011), 1'b0, 1'b1);
    run_c("R11 nop with imm hint", c_ci(0, 0, 7, 2'b01), e_i(7, 0, 0, 0, 7'b0010011), 1'b0, 1'b1);
  endtask

  task automatic t_shifts();
    run_c("R12 srli x9,31", c_sh(0, 1, 31), e_i(31, 9, 5, 9, 7'b0010011), 1'b0, 1'b0);
    run_c("R12 srai x12,1", c_sh(1, 4, 1), e_i(12'h401, 12, 5, 12, 7'b0010011), 1'b0, 1'b0);
    run_c("R12 srli shamt5 illegal", c_sh(0, 1, 32), 32'h0, 1'b1, 1'b0);
    run_c("R12 srai zero shamt hint", c_sh(1, 2, 0), e_i(12'h400, 10, 5, 10, 7'b0010011), 1'b0, 1'b1);
    run_c("R12 andi x14,-1", c_sh(2, 6, -1), e_i(-1, 14, 7, 14, 7'b0010011), 1'b0, 1'b0);
    run_c("R12 slli x1,5", c_ci(0, 1, 5, 2'b10), e_i(5, 1, 1, 1, 7'b0010011), 1'b0, 1'b0);
    run_c("R12 slli shamt5 illegal", c_ci(0, 1, 33, 2'b10), 32'h0, 1'b1, 1'b0);
    run_c("R12 slli rd x0 hint", c_ci(0, 0, 3, 2'b10), e_i(3, 0, 1, 0, 7'b0010011), 1'b0, 1'b1);
  endtask

  task automatic t_unsupported();
    run_c("R13 jump-register form illegal", 16'h8082, 32'h0, 1'b1, 1'b0);
    run_c("R13 fp load form illegal", 16'h2000, 32'h0, 1'b1, 1'b0);
    run_c("R13 reg-reg arith illegal", {3'b100, 1'b0, 2'b11, 3'b001, 2'b00, 3'b010, 2'b01}, 32'h0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0;
    in_word  = 32'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_idle();
    t_passthru();
    t_spn();
    t_reg_mem();
    t_sp_mem();
    t_jumps();
    t_branches();
    t_li();
    t_lui_a16();
    t_addi();
    t_shifts();
    t_unsupported();
    drive(1'b0, 32'h0);
    expect_out("R1 idle at end", 1'b0, 32'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule